// File: doc/BRIEF.md
# Programmable Square-Wave Interrupt Output

This block drives one output pin with a square wave whose timing comes from the bus clock. A prescaler divides the bus clock into ticks. Software writes a control word that holds a 16-bit reload value, a 3-bit operating mode and a diagnostic flag. In the toggle mode the output level inverts once every reload+1 ticks, so one full period of the wave is 2*(reload+1) ticks. In every other mode the output stays low.

A second register, the pad control word, sets whether the pin is driven. The pin is driven only when both its direction bit and its enable bit are set. The live output level is returned in the top bit of the control word, so software can poll that bit and time the edges of the wave against its own clock. This lets software measure the bus clock frequency. Writing zero to the control word puts the generator back into its power-on state.

Top module: `sqw_irq_gen`

## Requirements
- R1: After reset the control word reads 0, the pad control word reads 0, and both `pin_oe` and `pin_out` are 0.
- R2: The control word layout is reload value in bits 15:0, mode in bits 18:16, diagnostic flag in bit 19 and the live output level in bit 31. Bits 30:20 read as zero, and the written fields read back unchanged.
- R3: Mode 7 (toggle) inverts the level each time reload+1 ticks have elapsed, which gives a full period of 2*(reload+1) ticks. This holds for reload values 0 through 5 and for a large value (300).
- R4: One tick occurs every DIV bus clocks (DIV defaults to 4). The first tick after a control write falls DIV clocks after that write, so in mode 7 the level read after n clocks equals floor(n / ((reload+1)*DIV)) mod 2.
- R5: Every control write forces the level to 0 in the next cycle and restarts the prescaler and the tick counter from the new reload value, even while the level is high.
- R6: Writing zero to the control word makes every field read 0 and keeps the output low.
- R7: A mode other than 7 holds the level at 0 for as long as that mode is selected.
- R8: The diagnostic flag has no effect on the waveform.
- R9: In the pad control word, bit 0 is direction and bit 1 is enable. `pin_oe` is 1 only when both bits are 1. `pin_out` equals the level while the pin is driven and is 0 otherwise. The pad control word reads back its two bits.
- R10: A write to the pad control word does not change the timing of the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 pad control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 pad control word |
| rd_data | output | 32 | Combinational read data |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin driver enable |

## Verification
A wrong prescaler phase or a counter that reloads one tick early or late moves the first edge after a write. That error shows in the live-level bit within (reload+1)*DIV clocks, and it grows with each later edge. The bench therefore compares the level on every clock over several periods for each reload value. If a control write fails to clear the level, the wrong value appears in the cycle just after the write. If pad writes disturb the timing, an edge moves inside the same run. If the gating is wrong, `pin_out` differs from the level on the first cycle the level is high.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
    localparam int CNT_W   = 16;
    localparam int MODE_W  = 3;
    localparam int MODE_LSB  = CNT_W;
    localparam int DIAG_BIT  = MODE_LSB + MODE_W;
    localparam int LEVEL_BIT = 31;
    localparam int GP_DIR_BIT = 0;
    localparam int GP_EN_BIT  = 1;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'd7;

    typedef struct packed {
        logic              diag;
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  reload;
    } ctrl_t;

    typedef struct packed {
        logic en;
        logic dir;
    } pad_t;
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            typedef struct packed {
                logic [PW-1:0] phase;
            } pre_t;

            pre_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (restart || s_q.phase == LAST) begin
                    s_d.phase = '0;
                end else begin
                    s_d.phase = s_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign tick = (s_q.phase == LAST);

            // R4
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
            // R4
            phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.phase <= LAST);
        end
    endgenerate
endmodule

// File: rtl/sqw_wave_core.sv
module sqw_wave_core
    import sqw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  ctrl_t new_ctrl,
    input  logic  tick,
    output ctrl_t ctrl,
    output logic  level
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] remain;
        logic             level;
    } core_t;

    core_t s_d, s_q;
    logic  toggling;

    assign toggling = (s_q.ctrl.mode == MODE_TOGGLE);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.ctrl   = new_ctrl;
            s_d.remain = new_ctrl.reload;
            s_d.level  = 1'b0;
        end else if (toggling && tick) begin
            if (s_q.remain == '0) begin
                s_d.level  = ~s_q.level;
                s_d.remain = s_q.ctrl.reload;
            end else begin
                s_d.remain = s_q.remain - 1'b1;
            end
        end else if (!toggling) begin
            s_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl  = s_q.ctrl;
    assign level = s_q.level;

    // R3
    remain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.remain <= s_q.ctrl.reload);
    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(s_q.level));
    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !toggling |-> !s_q.level);
endmodule

// File: rtl/sqw_irq_gen.sv
module sqw_irq_gen
    import sqw_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        pin_out,
    output logic        pin_oe
);
    localparam int PAD_BITS = 2;

    typedef struct packed {
        pad_t pad;
    } top_t;

    top_t  s_d, s_q;
    logic  ctrl_wr, pad_wr, tick, level;
    ctrl_t ctrl, new_ctrl;
    logic  unused_wr_bits;

    assign ctrl_wr = wr_en && !wr_sel;
    assign pad_wr  = wr_en && wr_sel;

    assign new_ctrl.reload = wr_data[CNT_W-1:0];
    assign new_ctrl.mode   = wr_data[MODE_LSB +: MODE_W];
    assign new_ctrl.diag   = wr_data[DIAG_BIT];
    assign unused_wr_bits  = ^wr_data[31:DIAG_BIT+1];

    always_comb begin
        s_d = s_q;
        if (pad_wr) begin
            s_d.pad.dir = wr_data[GP_DIR_BIT];
            s_d.pad.en  = wr_data[GP_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sqw_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .tick    (tick)
    );

    sqw_wave_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctrl_wr),
        .new_ctrl (new_ctrl),
        .tick     (tick),
        .ctrl     (ctrl),
        .level    (level)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[GP_DIR_BIT] = s_q.pad.dir;
            rd_data[GP_EN_BIT]  = s_q.pad.en;
        end else begin
            rd_data[CNT_W-1:0]          = ctrl.reload;
            rd_data[MODE_LSB +: MODE_W] = ctrl.mode;
            rd_data[DIAG_BIT]           = ctrl.diag;
            rd_data[LEVEL_BIT]          = level;
        end
    end

    assign pin_oe  = s_q.pad.dir && s_q.pad.en;
    assign pin_out = pin_oe && level;

    // R5
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !level);
    // R7
    rise_needs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> (ctrl.mode == MODE_TOGGLE));
    // R9
    pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data & {32{rd_sel}}) <= PAD_BITS);
endmodule

// File: tb/sim_sqw_irq_gen.sv
`timescale 1ns/1ps
module sim_sqw_irq_gen;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        pin_out, pin_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [1:0] pad_exp = 2'b00;

    always #2.5 clk = ~clk;

    sqw_irq_gen #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cword(input int rl, input int md, input bit dg);
        return {12'b0, dg, md[2:0], rl[15:0]};
    endfunction

    // write at the next rising edge; returns at the falling edge after it
    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) pad_exp = d[1:0];
    endtask

    task automatic run_wave(input int rl, input bit dg, input int ncyc,
                            input int pad_at, input logic [1:0] pad_val);
        logic [1:0] pad_now;
        wr(1'b0, cword(rl, 7, dg));
        rd_sel = 1'b0;
        pad_now = pad_exp;
        for (int n = 0; n <= ncyc; n++) begin
            logic lvl;
            lvl = ((n / ((rl + 1) * DIV)) % 2) == 1;
            if (n == 0) chk("R5 level cleared by write", {31'b0, rd_data[31]}, 32'd0);
            else        chk("R3/R4/R8/R10 level", {31'b0, rd_data[31]}, {31'b0, lvl});
            chk("R9 pin_out", {31'b0, pin_out}, {31'b0, lvl & (&pad_now)});
            if (n == pad_at) begin
                wr_en = 1'b1; wr_sel = 1'b1; wr_data = {30'b0, pad_val};
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            if (n == pad_at) begin
                pad_now = pad_val;
                pad_exp = pad_val;
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_sel = 1'b0; #0.1;
        chk("R1 control after reset", rd_data, 32'd0);
        rd_sel = 1'b1; #0.1;
        chk("R1 pad after reset", rd_data, 32'd0);
        chk("R1 pin_oe", {31'b0, pin_oe}, 32'd0);
        chk("R1 pin_out", {31'b0, pin_out}, 32'd0);

        // R2 field readback, R7 idle modes
        wr(1'b0, cword(16'h1234, 3, 1'b1) | 32'hFFF0_0000);
        rd_sel = 1'b0; #0.1;
        chk("R2 readback", rd_data, 32'h000B_1234);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            chk("R7 mode 3 low", {31'b0, rd_data[31]}, 32'd0);
        end
        wr(1'b0, cword(0, 0, 1'b0));
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            chk("R7 mode 0 low", {31'b0, rd_data[31]}, 32'd0);
        end
        wr(1'b0, cword(1, 6, 1'b0));
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            chk("R7 mode 6 low", {31'b0, rd_data[31]}, 32'd0);
        end

        // R9 pad combinations
        for (int g = 0; g < 4; g++) begin
            wr(1'b1, 32'(g) | 32'hFFFF_FFFC);
            rd_sel = 1'b1; #0.1;
            chk("R9 pad readback", rd_data, 32'(g));
            chk("R9 pin_oe", {31'b0, pin_oe}, {31'b0, g == 3});
        end
        rd_sel = 1'b0;

        // R3 R4 R8 R10 sweep; R5 via rewrite while running
        for (int rl = 0; rl <= 5; rl++) begin
            int pa;
            logic [1:0] pv;
            pa = -1; pv = 2'b11;
            if (rl == 3) begin pa = 7;  pv = 2'b01; end
            if (rl == 4) begin pa = 13; pv = 2'b11; end
            run_wave(rl, rl[0], 5 * (rl + 1) * DIV, pa, pv);
        end
        run_wave(2, 1'b0, 14, -1, 2'b11);   // level high at end
        run_wave(1, 1'b1, 20, -1, 2'b11);   // R5 rewrite clears

        // R6 write zero
        wr(1'b0, 32'd0);
        #0.1;
        chk("R6 zero readback", rd_data, 32'd0);
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            chk("R6 stays low", {31'b0, rd_data[31]}, 32'd0);
        end

        // R3 R4 large reload
        run_wave(300, 1'b0, 2 * 301 * DIV + 8, -1, 2'b11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule